// File: doc/BRIEF.md
# Control Store Image Loader

This block copies a microcode image from main memory into a wide writable control store. The image is a packed list of three-word entries. The first word of an entry carries the target microword address in its upper bits. The next two words carry the contents of the two halves of that microword. After a start pulse the loader reads the image word by word from a base address. For each entry it makes two single-clock write strobes into the control store, one for each half.

The image has no length field. The walk ends only when an entry's target address is all ones, which is 12'hFFF with the default width. A damaged image with no terminator would keep the loader reading memory for ever. For that reason a guard counts the entries that have been written and stops the walk with a timeout flag once a parameterised limit is reached.

The main-memory read side uses two valid/ready channels: one for the request address and one for the returned data. A request stays valid, with its address unchanged, until the memory accepts it. A returned word is taken only in a cycle where the loader raises its response ready. The loader has at most one word in flight, so the memory must not return a word before it has accepted the matching request. The control-store write port and the start/busy/done/timeout pins are plain signals.

Top module: `csl_loader`

## Requirements
- R1: After reset, busy, done, timeout, mem_req_valid, mem_rsp_ready and cs_we are all low, and they stay so until start is asserted.
- R2: A start in an idle cycle latches base_addr. Memory words are requested one at a time at base_addr, base_addr+1, base_addr+2, and so on, with no gaps and no repeats.
- R3: The target address is the top CS_AW bits of the first word of an entry (bits 15:4 with the defaults). The remaining low bits of that word have no effect.
- R4: For each non-terminator entry the loader asserts cs_we for exactly two consecutive cycles, both at the entry's target address. In the first cycle cs_half=0 and cs_data is the second word of the entry. In the second cycle cs_half=1 and cs_data is the third word.
- R5: An entry whose target address is all ones ends the load. Only its first word is read, no write strobe is made for it, and in the following cycle busy falls and done rises. done then stays high until the next start.
- R6: There is no length count. Entries keep being read and written in memory order until a terminator or the entry limit ends the walk.
- R7: After MAX_ENTRIES entries have been written, the walk stops before any further read, even if a terminator follows: busy falls, timeout rises and done stays low.
- R8: A start pulse while busy is high is ignored. It affects neither the base address nor the sequence of reads and writes.
- R9: While mem_req_valid is high and mem_req_ready is low, the request and its address stay unchanged. A returned word is consumed only when mem_rsp_valid and mem_rsp_ready are both high.
- R10: done and busy are never high together, and neither are done and timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a load; taken only when idle |
| base_addr | input | MEM_AW | Memory address of the first image word |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load ended on a terminator |
| timeout | output | 1 | Last load ended at the entry limit |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | MEM_AW | Word address being read |
| mem_rsp_valid | input | 1 | Returned word valid |
| mem_rsp_ready | output | 1 | Loader can take the returned word |
| mem_rsp_data | input | WORD_W | Returned word |
| cs_we | output | 1 | Control-store write strobe, one clock per half |
| cs_half | output | 1 | 0 selects the first half, 1 the second half |
| cs_addr | output | CS_AW | Microword address for the write |
| cs_data | output | WORD_W | Data for the selected half |

## Verification
The functions that can fall in the same cycle are a control-store write strobe and a start request that arrives while a load is running. The bench pulses start in the middle of a walk and at the same time changes base_addr to a different region. It then requires the logged reads and writes to match exactly those of an undisturbed load from the original base. The other coincidence is the entry limit being reached just before a terminator. An image with exactly MAX_ENTRIES entries followed by a terminator must end in timeout, without reading the terminator.

// File: rtl/csl_pkg.sv
package csl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_WR0,
    ST_WR1
  } csl_state_e;

  typedef enum logic [1:0] {
    SLOT_TGT,
    SLOT_LO,
    SLOT_HI
  } csl_slot_e;
endpackage

// File: rtl/csl_rd_ptr.sv
module csl_rd_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= base;
    else if (adv)  ptr <= ptr + AW'(1);
  end
endmodule

// File: rtl/csl_entry_guard.sv
module csl_entry_guard #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic at_last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + CW'(1);
  end

  assign at_last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/csl_loader.sv
module csl_loader
  import csl_pkg::*;
#(
  parameter int MEM_AW      = 16,
  parameter int WORD_W      = 16,
  parameter int CS_AW       = 12,
  parameter int MAX_ENTRIES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MEM_AW-1:0] base_addr,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              cs_we,
  output logic              cs_half,
  output logic [CS_AW-1:0]  cs_addr,
  output logic [WORD_W-1:0] cs_data
);
  localparam logic [CS_AW-1:0] TERM = '1;

  csl_state_e state;
  csl_slot_e  slot;
  logic [CS_AW-1:0]  tgt;
  logic [WORD_W-1:0] lo_q, hi_q;
  logic [CS_AW-1:0]  field;
  logic              take, ptr_load, ptr_adv, guard_last, entry_done;

  assign field      = mem_rsp_data[WORD_W-1 -: CS_AW];
  assign take       = (state == ST_RSP) && mem_rsp_valid;
  assign ptr_load   = (state == ST_IDLE) && start;
  assign ptr_adv    = (state == ST_REQ) && mem_req_ready;
  assign entry_done = (state == ST_WR1);

  csl_rd_ptr #(.AW(MEM_AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .base(base_addr),
    .adv(ptr_adv), .ptr(mem_req_addr)
  );

  csl_entry_guard #(.LIMIT(MAX_ENTRIES)) u_guard (
    .clk(clk), .rst_n(rst_n), .clear(ptr_load), .bump(entry_done),
    .at_last(guard_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      slot    <= SLOT_TGT;
      tgt     <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_REQ;
          slot    <= SLOT_TGT;
          done    <= 1'b0;
          timeout <= 1'b0;
        end
        ST_REQ: if (mem_req_ready) state <= ST_RSP;
        ST_RSP: if (take) begin
          unique case (slot)
            SLOT_TGT: begin
              tgt <= field;
              if (field == TERM) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                slot  <= SLOT_LO;
                state <= ST_REQ;
              end
            end
            SLOT_LO: begin
              lo_q  <= mem_rsp_data;
              slot  <= SLOT_HI;
              state <= ST_REQ;
            end
            default: begin
              hi_q  <= mem_rsp_data;
              state <= ST_WR0;
            end
          endcase
        end
        ST_WR0: state <= ST_WR1;
        default: begin
          if (guard_last) begin
            state   <= ST_IDLE;
            timeout <= 1'b1;
          end else begin
            slot  <= SLOT_TGT;
            state <= ST_REQ;
          end
        end
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_rsp_ready = (state == ST_RSP);
  assign cs_we         = (state == ST_WR0) || (state == ST_WR1);
  assign cs_half       = (state == ST_WR1);
  assign cs_addr       = tgt;
  assign cs_data       = (state == ST_WR1) ? hi_q : lo_q;
endmodule

// File: rtl/csl_loader_chk.sv
module csl_loader_chk #(
  parameter int MEM_AW = 16,
  parameter int WORD_W = 16,
  parameter int CS_AW  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [MEM_AW-1:0] base_addr,
  input logic              busy,
  input logic              done,
  input logic              timeout,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [MEM_AW-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic [WORD_W-1:0] mem_rsp_data,
  input logic              cs_we,
  input logic              cs_half,
  input logic [CS_AW-1:0]  cs_addr,
  input logic [WORD_W-1:0] cs_data
);
  logic              seen;
  logic [MEM_AW-1:0] prev_addr;
  logic              accept;

  assign accept = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      prev_addr <= '0;
    end else if (start && !busy) begin
      seen <= 1'b0;
    end else if (accept) begin
      seen      <= 1'b1;
      prev_addr <= mem_req_addr;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cs_we && !mem_req_valid && !mem_rsp_ready));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && seen) |-> (mem_req_addr == prev_addr + MEM_AW'(1)));

  assert_half_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_we && !cs_half) |=> (cs_we && cs_half && $stable(cs_addr)));

  assert_strobe_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_we && cs_half) |=> !cs_we);

  assert_no_term_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_we |-> (cs_addr != {CS_AW{1'b1}}));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_flag_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy) && !(done && timeout));
endmodule

bind csl_loader csl_loader_chk #(.MEM_AW(MEM_AW), .WORD_W(WORD_W), .CS_AW(CS_AW)) u_chk (.*);

// File: tb/test_csl_loader.sv
module test_csl_loader;
  localparam int MEM_AW = 16;
  localparam int WORD_W = 16;
  localparam int CS_AW  = 12;
  localparam int LIMIT  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [MEM_AW-1:0] base_addr = '0;
  logic busy, done, timeout;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [MEM_AW-1:0] mem_req_addr;
  logic [WORD_W-1:0] mem_rsp_data;
  logic cs_we, cs_half;
  logic [CS_AW-1:0] cs_addr;
  logic [WORD_W-1:0] cs_data;

  always #2 clk = ~clk;

  csl_loader #(.MEM_AW(MEM_AW), .WORD_W(WORD_W), .CS_AW(CS_AW), .MAX_ENTRIES(LIMIT)) i_csl_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .busy(busy), .done(done), .timeout(timeout),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .cs_we(cs_we), .cs_half(cs_half), .cs_addr(cs_addr), .cs_data(cs_data)
  );

  // memory model
  logic [WORD_W-1:0] mem [0:63];
  logic [3:0] lfsr = 4'b1001;
  logic bp_on = 1'b0;
  logic [2:0] lat = 3'd0;
  logic pend = 1'b0;
  logic [2:0] dly = 3'd0;
  logic [WORD_W-1:0] rdat = '0;

  assign mem_req_ready = bp_on ? lfsr[0] : 1'b1;
  assign mem_rsp_valid = pend && (dly == 3'd0);
  assign mem_rsp_data  = rdat;

  always @(posedge clk) begin
    lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
    if (mem_req_valid && mem_req_ready) begin
      pend <= 1'b1;
      dly  <= lat;
      rdat <= mem[mem_req_addr[5:0]];
    end else if (pend && dly != 3'd0) begin
      dly <= dly - 3'd1;
    end else if (pend && mem_rsp_ready) begin
      pend <= 1'b0;
    end
  end

  // logging
  logic clr_log = 1'b0;
  int nw = 0;
  int nr = 0;
  logic [MEM_AW-1:0] last_ra = '0;
  logic [CS_AW-1:0] wa [0:31];
  logic wh [0:31];
  logic [WORD_W-1:0] wd [0:31];

  always @(posedge clk) begin
    if (clr_log) begin
      nw <= 0;
      nr <= 0;
    end else begin
      if (cs_we && nw < 32) begin
        wa[nw] <= cs_addr;
        wh[nw] <= cs_half;
        wd[nw] <= cs_data;
        nw <= nw + 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        nr <= nr + 1;
        last_ra <= mem_req_addr;
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  logic [CS_AW-1:0] ea [0:15];
  logic [WORD_W-1:0] e0 [0:15];
  logic [WORD_W-1:0] e1 [0:15];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  task automatic put_entry(input int base, input int k, input logic [CS_AW-1:0] a,
                           input logic [3:0] lowbits);
    ea[k] = a;
    e0[k] = 16'hA000 + 16'(k);
    e1[k] = 16'h5000 + 16'(k * 3);
    mem[(base + 3 * k) % 64]     = {a, lowbits};
    mem[(base + 3 * k + 1) % 64] = e0[k];
    mem[(base + 3 * k + 2) % 64] = e1[k];
  endtask

  task automatic put_term(input int pos, input logic [3:0] lowbits);
    mem[pos % 64] = {{CS_AW{1'b1}}, lowbits};
  endtask

  task automatic pulse_start(input logic [MEM_AW-1:0] b);
    @(negedge clk);
    clr_log = 1'b1;
    @(negedge clk);
    clr_log = 1'b0;
    base_addr = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic check_writes(input int n, input string req);
    bit ok;
    chk(nw == 2 * n, req, nw, 2 * n);
    for (int k = 0; k < n; k++) begin
      ok = (wa[2*k] == ea[k]) && (wh[2*k] == 1'b0) && (wd[2*k] == e0[k]) &&
           (wa[2*k+1] == ea[k]) && (wh[2*k+1] == 1'b1) && (wd[2*k+1] == e1[k]);
      chk(ok, req, {wa[2*k], wd[2*k]}, {ea[k], e0[k]});
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !timeout, "R1", {busy, done, timeout}, 0);
    chk(!mem_req_valid && !mem_rsp_ready && !cs_we, "R1",
        {mem_req_valid, mem_rsp_ready, cs_we}, 0);
  endtask

  // R2 R4 R5 R6: plain three-entry load
  task automatic t_basic();
    clear_mem();
    put_entry(0, 0, 12'h010, 4'h0);
    put_entry(0, 1, 12'h3A5, 4'h0);
    put_entry(0, 2, 12'h000, 4'h0);
    put_term(9, 4'h0);
    pulse_start(16'd0);
    chk(busy && !done, "R5", {busy, done}, 2);
    wait_idle();
    chk(done && !timeout, "R5", {done, timeout}, 2);
    check_writes(3, "R4");
    chk(nr == 10, "R2", nr, 10);
    chk(last_ra == 16'd9, "R2", last_ra, 9);
    repeat (5) @(negedge clk);
    chk(done && !busy, "R5", {done, busy}, 2);
  endtask

  // R3 R2: low bits ignored, non-zero base, backpressure and latency
  task automatic t_lowbits();
    clear_mem();
    bp_on = 1'b1;
    lat = 3'd3;
    put_entry(20, 0, 12'h7F0, 4'hF);
    put_entry(20, 1, 12'hFFE, 4'hA);
    put_term(26, 4'h5);
    pulse_start(16'd20);
    wait_idle();
    chk(done && !timeout, "R3", {done, timeout}, 2);
    check_writes(2, "R3");
    chk(nr == 7 && last_ra == 16'd26, "R2", {nr[15:0], last_ra}, {16'd7, 16'd26});
    bp_on = 1'b0;
    lat = 3'd0;
  endtask

  // R5: immediate terminator
  task automatic t_empty();
    clear_mem();
    put_term(40, 4'h0);
    pulse_start(16'd40);
    wait_idle();
    chk(done && nw == 0 && nr == 1, "R5", nw, 0);
  endtask

  // R6 R7: no terminator
  task automatic t_runaway();
    clear_mem();
    for (int k = 0; k < 8; k++) put_entry(30, k, 12'(12'h100 + k), 4'h0);
    pulse_start(16'd30);
    wait_idle();
    chk(timeout && !done && !busy, "R7", {timeout, done, busy}, 4);
    check_writes(LIMIT, "R6");
    chk(nr == 3 * LIMIT, "R7", nr, 3 * LIMIT);
  endtask

  // R7: terminator right after limit is never read
  task automatic t_limit_edge();
    clear_mem();
    for (int k = 0; k < LIMIT; k++) put_entry(0, k, 12'(12'h200 + k), 4'h0);
    put_term(3 * LIMIT, 4'h0);
    pulse_start(16'd0);
    wait_idle();
    chk(timeout && !done, "R7", {timeout, done}, 2);
    chk(nr == 3 * LIMIT && last_ra == 16'(3 * LIMIT - 1), "R7", nr, 3 * LIMIT);
  endtask

  // R8: start while busy (during a write strobe)
  task automatic t_restart_ignored();
    clear_mem();
    put_entry(0, 0, 12'h010, 4'h0);
    put_entry(0, 1, 12'h3A5, 4'h0);
    put_entry(0, 2, 12'h000, 4'h0);
    put_term(9, 4'h0);
    mem[50] = 16'hFFF0;
    pulse_start(16'd0);
    for (int i = 0; i < 100; i++) begin
      if (cs_we) break;
      @(negedge clk);
    end
    base_addr = 16'd50;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk(done, "R8", done, 1);
    check_writes(3, "R8");
    chk(nr == 10 && last_ra == 16'd9, "R8", last_ra, 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_lowbits();
    t_empty();
    t_runaway();
    t_limit_edge();
    t_restart_ignored();
    repeat (3) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end
endmodule